// File: doc/BRIEF.md
# Strided Banked Vector Load Engine

This block fetches the elements of one vector load whose addresses are spaced by a constant stride. The memory is split into interleaved banks. Element `i` lives at `base + i * stride`, counted in element units. The low bits of that address pick the bank and the upper bits pick the row inside it. Each bank stays occupied for a fixed number of cycles after it serves a read. When the next element targets a bank that is still occupied, issue waits. The total load time therefore depends on how the stride relates to the bank count.

Every read returns after a fixed memory latency. Results leave the block as a stream of words, each tagged with its element index. Because issue is strictly in order, the stream is in order too. A one-cycle completion pulse follows the last element. The storage is a read-only internal array model. Each word is derived from its own address, so a consumer can tell exactly which location was read.

Top module: `strided_bank_loader`

## Requirements
- R1: Element `i` is read from element address `A = (base + i*stride) mod 2^ADDR_W`. The word stored at `A` is `{~A, A}`: the upper ADDR_W bits hold the inverted address and the lower ADDR_W bits hold the address. The word is delivered on `elem_data_o` together with `elem_idx_o = i`.
- R2: The bank of address `A` is `A mod N_BANKS`, which is the low `log2(N_BANKS)` bits of A. The row is the remaining upper bits.
- R3: At most one element is issued per cycle, and at most one bank is addressed per cycle. The first element is issued on the clock edge that follows the edge on which `start_i` was accepted.
- R4: Once a bank has been accessed, it accepts no further access for BANK_BUSY cycles. An element whose bank is busy stalls issue of itself and of every later element.
- R5: Each element appears on the output MEM_LAT cycles after its issue edge. Elements appear in ascending index order with no gaps. With stride 1 and length 64, `done_o` rises 12 + 64 = 76 cycles after the start edge.
- R6: When the stride is a multiple of N_BANKS, every access after the first conflicts with the previous one. A load of length L then takes 12 + 1 + 6*(L-1) cycles, which is 391 cycles for L = 64.
- R7: `done_o` is a single-cycle pulse, raised on the cycle after the last element is output. It is never high in the same cycle as `elem_valid_o`.
- R8: A vector length of zero performs no memory access and outputs no element. In that case `done_o` pulses one cycle after the start edge.
- R9: A vector length greater than MAX_VL (64) is treated as MAX_VL.
- R10: `start_i` is ignored from the start edge until `done_o` has pulsed. During that window, neither the element stream nor the completion time changes.
- R11: While reset is asserted and after it is released, `elem_valid_o` and `done_o` are low until a load starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load; sampled only when idle |
| base_i | input | ADDR_W | Element address of element 0 |
| stride_i | input | ADDR_W | Address step between elements, in element units |
| vlen_i | input | VL_W | Number of elements requested |
| elem_valid_o | output | 1 | A returned element is present |
| elem_idx_o | output | IDX_W | Index of the returned element |
| elem_data_o | output | 2*ADDR_W | Returned element word |
| done_o | output | 1 | One-cycle pulse when the load has completed |

## Verification
The bench uses the default build: 8 banks, a busy time of 6 cycles, a latency of 12 cycles, a maximum length of 64 and 8-bit element addresses. These are the values for which the textbook timings of 76 and 391 cycles apply exactly, so both figures can be checked cycle for cycle.

The small 256-word address space lets a stride-32 load of 64 elements wrap several times. Bases near the top of the space also wrap, which exercises the modulo addressing. A stride of 2 cycles through 4 banks and a stride of 4 alternates between 2 banks, so a partial conflict pattern can be told apart from the no-conflict case and from the all-conflict case.

// File: rtl/vld_pkg.sv
package vld_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ISSUE = 2'd1,
        LD_DRAIN = 2'd2
    } ld_state_e;

    localparam int DEF_ADDR_W  = 8;
    localparam int DEF_N_BANKS = 8;
    localparam int DEF_BUSY    = 6;
    localparam int DEF_MEM_LAT = 12;
    localparam int DEF_MAX_VL  = 64;

    function automatic int vl_width(input int max_vl);
        return $clog2(max_vl + 1);
    endfunction

endpackage

// File: rtl/vld_bank.sv
module vld_bank #(
    parameter int ADDR_W  = 8,
    parameter int N_BANKS = 8,
    parameter int BUSY    = 6,
    parameter int BANK_ID = 0,
    localparam int BSEL_W = $clog2(N_BANKS),
    localparam int ROW_W  = ADDR_W - BSEL_W,
    localparam int ROWS   = 1 << ROW_W,
    localparam int DATA_W = 2 * ADDR_W,
    localparam int CNT_W  = $clog2(BUSY + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              free_o
);

    logic [DATA_W-1:0] mem [ROWS];
    logic [CNT_W-1:0]  busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= {~ADDR_W'(r * N_BANKS + BANK_ID), ADDR_W'(r * N_BANKS + BANK_ID)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (req_i) begin
            busy_cnt <= CNT_W'(BUSY - 1);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign free_o    = (busy_cnt == '0);
    assign rd_data_o = mem[row_i];

endmodule

// File: rtl/vld_issue.sv
module vld_issue
    import vld_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int N_BANKS = 8,
    parameter int MAX_VL  = 64,
    localparam int BSEL_W = $clog2(N_BANKS),
    localparam int ROW_W  = ADDR_W - BSEL_W,
    localparam int VL_W   = vl_width(MAX_VL),
    localparam int IDX_W  = $clog2(MAX_VL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [ADDR_W-1:0]  stride_i,
    input  logic [VL_W-1:0]    vlen_i,
    input  logic [N_BANKS-1:0] bank_free_i,
    input  logic               done_i,
    output logic [N_BANKS-1:0] bank_req_o,
    output logic [BSEL_W-1:0]  bank_sel_o,
    output logic [ROW_W-1:0]   row_o,
    output logic               fire_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               last_o,
    output logic               zero_done_o
);

    ld_state_e         st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx_q;
    logic              zero_q;
    logic [VL_W-1:0]   vl_eff;

    assign vl_eff      = (vlen_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vlen_i;
    assign bank_sel_o  = addr_q[BSEL_W-1:0];
    assign row_o       = addr_q[ADDR_W-1:BSEL_W];
    assign fire_o      = (st_q == LD_ISSUE) && bank_free_i[bank_sel_o];
    assign idx_o       = idx_q;
    assign last_o      = (idx_q == last_idx_q);
    assign zero_done_o = zero_q;

    always_comb begin
        bank_req_o = '0;
        if (fire_o) begin
            bank_req_o[bank_sel_o] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= LD_IDLE;
            addr_q     <= '0;
            stride_q   <= '0;
            idx_q      <= '0;
            last_idx_q <= '0;
            zero_q     <= 1'b0;
        end else begin
            zero_q <= 1'b0;
            case (st_q)
                LD_IDLE: begin
                    if (start_i) begin
                        addr_q     <= base_i;
                        stride_q   <= stride_i;
                        idx_q      <= '0;
                        last_idx_q <= IDX_W'(vl_eff - 1'b1);
                        if (vl_eff == '0) begin
                            zero_q <= 1'b1;
                            st_q   <= LD_DRAIN;
                        end else begin
                            st_q <= LD_ISSUE;
                        end
                    end
                end
                LD_ISSUE: begin
                    if (fire_o) begin
                        addr_q <= addr_q + stride_q;
                        idx_q  <= idx_q + 1'b1;
                        if (last_o) begin
                            st_q <= LD_DRAIN;
                        end
                    end
                end
                default: begin
                    if (done_i) begin
                        st_q <= LD_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/vld_ret_pipe.sv
module vld_ret_pipe #(
    parameter int W   = 8,
    parameter int LAT = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid_i,
    input  logic [W-1:0] in_bits_i,
    output logic         out_valid_o,
    output logic [W-1:0] out_bits_o
);

    logic         vld_q  [LAT];
    logic [W-1:0] bits_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LAT; s++) begin
                vld_q[s] <= 1'b0;
            end
        end else begin
            vld_q[0] <= in_valid_i;
            for (int s = 1; s < LAT; s++) begin
                vld_q[s] <= vld_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        bits_q[0] <= in_bits_i;
        for (int s = 1; s < LAT; s++) begin
            bits_q[s] <= bits_q[s-1];
        end
    end

    assign out_valid_o = vld_q[LAT-1];
    assign out_bits_o  = bits_q[LAT-1];

endmodule

// File: rtl/strided_bank_loader.sv
module strided_bank_loader
    import vld_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int N_BANKS   = DEF_N_BANKS,
    parameter int BANK_BUSY = DEF_BUSY,
    parameter int MEM_LAT   = DEF_MEM_LAT,
    parameter int MAX_VL    = DEF_MAX_VL,
    localparam int BSEL_W   = $clog2(N_BANKS),
    localparam int ROW_W    = ADDR_W - BSEL_W,
    localparam int DATA_W   = 2 * ADDR_W,
    localparam int VL_W     = vl_width(MAX_VL),
    localparam int IDX_W    = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [VL_W-1:0]   vlen_i,
    output logic              elem_valid_o,
    output logic [IDX_W-1:0]  elem_idx_o,
    output logic [DATA_W-1:0] elem_data_o,
    output logic              done_o
);

    typedef struct packed {
        logic              last;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } ret_t;

    logic [N_BANKS-1:0] bank_req;
    logic [N_BANKS-1:0] bank_free;
    logic [BSEL_W-1:0]  bank_sel;
    logic [ROW_W-1:0]   row;
    logic               fire;
    logic [IDX_W-1:0]   issue_idx;
    logic               issue_last;
    logic               zero_done;
    logic [DATA_W-1:0]  rd_data [N_BANKS];
    ret_t               ret_in;
    ret_t               ret_out;
    logic               ret_valid;
    logic               done_q;

    vld_issue #(
        .ADDR_W (ADDR_W),
        .N_BANKS(N_BANKS),
        .MAX_VL (MAX_VL)
    ) u_issue (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .base_i     (base_i),
        .stride_i   (stride_i),
        .vlen_i     (vlen_i),
        .bank_free_i(bank_free),
        .done_i     (done_q),
        .bank_req_o (bank_req),
        .bank_sel_o (bank_sel),
        .row_o      (row),
        .fire_o     (fire),
        .idx_o      (issue_idx),
        .last_o     (issue_last),
        .zero_done_o(zero_done)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        vld_bank #(
            .ADDR_W (ADDR_W),
            .N_BANKS(N_BANKS),
            .BUSY   (BANK_BUSY),
            .BANK_ID(b)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .req_i    (bank_req[b]),
            .row_i    (row),
            .rd_data_o(rd_data[b]),
            .free_o   (bank_free[b])
        );
    end

    assign ret_in = '{last: issue_last, idx: issue_idx, data: rd_data[bank_sel]};

    vld_ret_pipe #(
        .W  ($bits(ret_t)),
        .LAT(MEM_LAT)
    ) u_ret (
        .clk        (clk),
        .rst        (rst),
        .in_valid_i (fire),
        .in_bits_i  (ret_in),
        .out_valid_o(ret_valid),
        .out_bits_o (ret_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (ret_valid && ret_out.last) || zero_done;
        end
    end

    assign elem_valid_o = ret_valid;
    assign elem_idx_o   = ret_out.idx;
    assign elem_data_o  = ret_out.data;
    assign done_o       = done_q;

endmodule

// File: rtl/strided_bank_loader_chk.sv
module strided_bank_loader_chk #(
    parameter int N_BANKS   = 8,
    parameter int BANK_BUSY = 6,
    parameter int IDX_W     = 6,
    localparam int GAP_W    = $clog2(BANK_BUSY + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [N_BANKS-1:0] bank_req,
    input logic               elem_valid_o,
    input logic [IDX_W-1:0]   elem_idx_o,
    input logic               done_o
);

    logic [IDX_W-1:0] next_idx_q;

    always_ff @(posedge clk) begin
        if (rst || done_o) begin
            next_idx_q <= '0;
        end else if (elem_valid_o) begin
            next_idx_q <= next_idx_q + 1'b1;
        end
    end

    assert_onehot_issue_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_req));

    assert_in_order_R5: assert property (@(posedge clk) disable iff (rst)
        elem_valid_o |-> (elem_idx_o == next_idx_q));

    assert_done_alone_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !elem_valid_o);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    for (genvar b = 0; b < N_BANKS; b++) begin : g_gap
        logic [GAP_W-1:0] gap_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                gap_q <= GAP_W'(BANK_BUSY);
            end else if (bank_req[b]) begin
                gap_q <= GAP_W'(1);
            end else if (gap_q < GAP_W'(BANK_BUSY)) begin
                gap_q <= gap_q + 1'b1;
            end
        end

        assert_bank_spacing_R4: assert property (@(posedge clk) disable iff (rst)
            bank_req[b] |-> (gap_q >= GAP_W'(BANK_BUSY)));
    end

endmodule

bind strided_bank_loader strided_bank_loader_chk #(
    .N_BANKS  (N_BANKS),
    .BANK_BUSY(BANK_BUSY),
    .IDX_W    (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bank_req    (bank_req),
    .elem_valid_o(elem_valid_o),
    .elem_idx_o  (elem_idx_o),
    .done_o      (done_o)
);

// File: tb/strided_bank_loader_bench.sv
module strided_bank_loader_bench;

    typedef struct packed {
        logic [7:0]  base;
        logic [7:0]  stride;
        logic [6:0]  vl;
        logic [6:0]  n_out;
        logic [15:0] cyc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{base: 8'd0,   stride: 8'd1,  vl: 7'd64, n_out: 7'd64, cyc: 16'd76},
        '{base: 8'd0,   stride: 8'd32, vl: 7'd64, n_out: 7'd64, cyc: 16'd391},
        '{base: 8'd3,   stride: 8'd8,  vl: 7'd10, n_out: 7'd10, cyc: 16'd67},
        '{base: 8'd5,   stride: 8'd2,  vl: 7'd16, n_out: 7'd16, cyc: 16'd34},
        '{base: 8'd0,   stride: 8'd4,  vl: 7'd8,  n_out: 7'd8,  cyc: 16'd32},
        '{base: 8'd7,   stride: 8'd3,  vl: 7'd20, n_out: 7'd20, cyc: 16'd32},
        '{base: 8'd250, stride: 8'd1,  vl: 7'd10, n_out: 7'd10, cyc: 16'd22},
        '{base: 8'd0,   stride: 8'd1,  vl: 7'd100, n_out: 7'd64, cyc: 16'd76}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  base_i = '0;
    logic [7:0]  stride_i = '0;
    logic [6:0]  vlen_i = '0;
    logic        elem_valid_o;
    logic [5:0]  elem_idx_o;
    logic [15:0] elem_data_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    strided_bank_loader u_strided_bank_loader (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .base_i      (base_i),
        .stride_i    (stride_i),
        .vlen_i      (vlen_i),
        .elem_valid_o(elem_valid_o),
        .elem_idx_o  (elem_idx_o),
        .elem_data_o (elem_data_o),
        .done_o      (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    // Runs one load; optionally pulses start with other operands at cycle intr (R10).
    task automatic run_load(input logic [7:0] b, input logic [7:0] s, input logic [6:0] vl,
                            input int exp_n, input int exp_cyc, input int intr, input string tag);
        int n = 0;
        int c = 0;
        bit seen_done = 1'b0;
        bit idx_ok = 1'b1;
        bit data_ok = 1'b1;
        bit overlap_ok = 1'b1;
        int bad_act = 0;
        int bad_exp = 0;
        @(negedge clk);
        base_i = b; stride_i = s; vlen_i = vl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!seen_done && c < 2000) begin
            @(negedge clk);
            c++;
            start_i = 1'b0;
            if (c == intr) begin
                base_i = 8'd9; stride_i = 8'd1; vlen_i = 7'd10; start_i = 1'b1;
            end
            if (elem_valid_o) begin
                logic [7:0] a;
                a = 8'(int'(b) + n * int'(s));
                if (elem_idx_o != 6'(n)) begin
                    idx_ok = 1'b0;
                end
                if (elem_data_o != {~a, a}) begin
                    data_ok = 1'b0; bad_act = int'(elem_data_o); bad_exp = int'({~a, a});
                end
                if (done_o) overlap_ok = 1'b0;
                n++;
            end
            if (done_o) seen_done = 1'b1;
        end
        start_i = 1'b0;
        check(idx_ok, {"R5 index order ", tag}, 0, 0);
        check(data_ok, {"R1 element word ", tag}, bad_act, bad_exp);
        check(overlap_ok, {"R7 done apart from data ", tag}, 1, 0);
        check(n == exp_n, {"R9 element count ", tag}, n, exp_n);
        check(c == exp_cyc, {"R4 completion cycle ", tag}, c, exp_cyc);
        repeat (3) begin
            @(negedge clk);
            check(!elem_valid_o && !done_o, {"R7 quiet after done ", tag},
                  int'(elem_valid_o) + int'(done_o), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!elem_valid_o && !done_o, "R11 outputs low in reset", int'(elem_valid_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!elem_valid_o && !done_o, "R11 outputs low after reset", int'(done_o), 0);

        // R1 R2 R3 R4 R5 R6 R9: table walk over strides and lengths
        for (int k = 0; k < NV; k++) begin
            run_load(TBL[k].base, TBL[k].stride, TBL[k].vl,
                     int'(TBL[k].n_out), int'(TBL[k].cyc), -1, $sformatf("vec%0d", k));
        end

        // R8: zero length completes one cycle after start, no elements
        run_load(8'd17, 8'd5, 7'd0, 0, 1, -1, "R8 zero length");

        // R10: start during a stride-32 load of 4 elements is ignored
        run_load(8'd0, 8'd32, 7'd4, 4, 31, 5, "R10 start ignored");

        // R6: single-bank stride multiple of bank count, length 2
        run_load(8'd1, 8'd16, 7'd2, 2, 19, -1, "R6 two conflicts");

        finish_run();
    end

endmodule